// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is the datapath controller of one DMA channel. Software-side logic loads a small set of registers (access widths, address-increment flags, burst limit, peripheral pacing, read address, write address and byte count) and then pulses `start`. The engine copies the requested number of bytes. It alternates a read beat and a write beat of the same length on a request/grant memory port. Each beat's read data is held in an internal register and written back out unchanged.

The beat length is the smallest of four limits: the read access size, the write access size, the bytes still to move and the bytes left in the current burst. A channel that serves a peripheral FIFO can hold either address fixed. It can also make every burst wait for the peripheral's request line. The bytes still to move can be read at any time, in minus-one form. A one-cycle `done` pulse marks the end of the transfer.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done` and `mem_req` are low and `remain` reads all ones.
- R2: Registers are written through `cfg_we`/`cfg_sel`/`cfg_wdata`. The select codes are 0 = mode word, 1 = port word, 2 = read address, 3 = write address and 4 = size (bits 23:0, byte count minus one). `start` copies the programmed values into working registers. While `busy`, a `start` pulse and any register writes have no effect on the running transfer.
- R3: The mode word holds the read width code in bits 2:0 and the write width code in bits 6:4, each as log2 of the access size in bytes. Codes above 3 act as 8 bytes. Each beat moves min(read size, write size, bytes remaining, burst bytes left) bytes, reported on `mem_len`.
- R4: Mode word bit 8 makes the read address advance by the beat length after each granted read. Bit 12 does the same for the write address. With a flag clear, that address stays at its programmed value.
- R5: Every beat is a read request (`mem_we`=0) followed by a write request (`mem_we`=1) of the same length. The low `mem_len` bytes of `mem_wdata` equal the bytes returned on `mem_rdata` with the read grant.
- R6: While `mem_req` is high and `mem_gnt` is low, the request, `mem_we`, `mem_addr` and `mem_len` hold their values into the next cycle.
- R7: `remain` holds the bytes still to move minus one. It drops by the beat length on each granted write and reads all ones once the transfer has finished.
- R8: `done` is high for exactly one cycle: the cycle after the final write grant. In that same cycle `busy` is low.
- R9: The burst size is port word bits 11:4, written as bytes minus one. The burst budget is the smaller of that value and a cap. The cap is BUS_BYTES*BURST_MULT (32 by default) when both programmed addresses are multiples of BUS_BYTES, and BUS_BYTES*(BURST_MULT-1) (24) otherwise.
- R10: With port word bit 1 set, the engine raises no memory request after `start` or after each completed burst until it samples `periph_req` high. The request follows one cycle after that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Begin a transfer (ignored while busy) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_len | output | 4 | Beat length in bytes (1..8) |
| mem_wdata | output | 64 | Write data, byte 0 in bits 7:0 |
| mem_rdata | input | 64 | Read data, valid with a read grant |
| mem_gnt | input | 1 | Grant; the beat completes at this edge |
| periph_req | input | 1 | Peripheral request used for pacing |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| remain | output | 24 | Bytes still to move, minus one |

## Verification
The bench samples every output at the falling edge. The request seen there was set by the previous rising edge and is checked against a bench model before the bench decides whether to grant it. A granted beat's effect on the addresses, the phase and `remain` is checked at the next falling edge, one register stage later. `done`, the all-ones `remain` and the low `busy` are due at the falling edge right after the final write grant, and `done` is checked low again one cycle later. Under pacing, a request is expected one cycle after the edge that samples `periph_req` high, so the bench holds the line low in the cycle a burst ends and counts request rises to confirm the number of bursts.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } xfer_state_e;

    typedef struct packed {
        logic [2:0] rd_wl;
        logic [2:0] wr_wl;
        logic       rd_inc;
        logic       wr_inc;
        logic       pace_en;
        logic [7:0] burst_m1;
    } chan_mode_t;

    localparam logic [2:0] SEL_MODE  = 3'd0;
    localparam logic [2:0] SEL_PORT  = 3'd1;
    localparam logic [2:0] SEL_RADDR = 3'd2;
    localparam logic [2:0] SEL_WADDR = 3'd3;
    localparam logic [2:0] SEL_SIZE  = 3'd4;

endpackage

// File: rtl/dxe_cfg_regs.sv
module dxe_cfg_regs #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 24,
    parameter int CFG_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output dxe_pkg::chan_mode_t mode,
    output logic [ADDR_W-1:0]   rd_base,
    output logic [ADDR_W-1:0]   wr_base,
    output logic [SIZE_W-1:0]   size_m1
);
    import dxe_pkg::*;

    typedef struct packed {
        chan_mode_t        mode;
        logic [ADDR_W-1:0] rd_base;
        logic [ADDR_W-1:0] wr_base;
        logic [SIZE_W-1:0] size_m1;
    } cfg_t;

    cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_MODE: begin
                    r_d.mode.rd_wl  = cfg_wdata[2:0];
                    r_d.mode.wr_wl  = cfg_wdata[6:4];
                    r_d.mode.rd_inc = cfg_wdata[8];
                    r_d.mode.wr_inc = cfg_wdata[12];
                end
                SEL_PORT: begin
                    r_d.mode.pace_en  = cfg_wdata[1];
                    r_d.mode.burst_m1 = cfg_wdata[11:4];
                end
                SEL_RADDR: r_d.rd_base = cfg_wdata[ADDR_W-1:0];
                SEL_WADDR: r_d.wr_base = cfg_wdata[ADDR_W-1:0];
                SEL_SIZE:  r_d.size_m1 = cfg_wdata[SIZE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode    = r_q.mode;
    assign rd_base = r_q.rd_base;
    assign wr_base = r_q.wr_base;
    assign size_m1 = r_q.size_m1;

endmodule

// File: rtl/dxe_burst_limit.sv
module dxe_burst_limit #(
    parameter int ADDR_W     = 32,
    parameter int BUS_BYTES  = 8,
    parameter int BURST_MULT = 4,
    parameter int BURST_W    = 9
) (
    input  logic [7:0]         burst_m1,
    input  logic [ADDR_W-1:0]  rd_base,
    input  logic [ADDR_W-1:0]  wr_base,
    output logic [BURST_W-1:0] limit
);
    localparam int OFS_W  = $clog2(BUS_BYTES);
    localparam int CAP_AL = BUS_BYTES * BURST_MULT;
    localparam int CAP_UN = BUS_BYTES * (BURST_MULT - 1);

    logic               aligned;
    logic [BURST_W-1:0] want;
    logic [BURST_W-1:0] cap;

    always_comb begin
        aligned = (rd_base[OFS_W-1:0] == '0) && (wr_base[OFS_W-1:0] == '0);
        want    = BURST_W'(burst_m1) + BURST_W'(1);
        cap     = aligned ? BURST_W'(CAP_AL) : BURST_W'(CAP_UN);
        limit   = (want < cap) ? want : cap;
    end

endmodule

// File: rtl/dxe_beat_calc.sv
module dxe_beat_calc #(
    parameter int BUS_BYTES = 8,
    parameter int SIZE_W    = 24,
    parameter int BURST_W   = 9,
    parameter int LEN_W     = 4
) (
    input  logic [2:0]         rd_wl,
    input  logic [2:0]         wr_wl,
    input  logic [SIZE_W-1:0]  remain_m1,
    input  logic [BURST_W-1:0] burst_left,
    output logic [LEN_W-1:0]   beat_len
);
    localparam int MAX_WL = $clog2(BUS_BYTES);
    localparam int CW     = SIZE_W + 1;

    function automatic logic [CW-1:0] unit_bytes(input logic [2:0] wl);
        logic [2:0] c;
        c = (int'(wl) > MAX_WL) ? 3'(MAX_WL) : wl;
        return CW'(1) << c;
    endfunction

    logic [CW-1:0] rb, wb, rem, bl, m;

    always_comb begin
        rb  = unit_bytes(rd_wl);
        wb  = unit_bytes(wr_wl);
        rem = {1'b0, remain_m1} + CW'(1);
        bl  = CW'(burst_left);
        m   = (rb < wb) ? rb : wb;
        if (rem < m) m = rem;
        if (bl < m)  m = bl;
        beat_len = LEN_W'(m);
    end

endmodule

// File: rtl/dxe_chan_ctrl.sv
module dxe_chan_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 24,
    parameter int BUS_BYTES = 8,
    parameter int BURST_W   = 9,
    parameter int LEN_W     = 4,
    parameter int DATA_W    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  dxe_pkg::chan_mode_t mode,
    input  logic [ADDR_W-1:0]   rd_base,
    input  logic [ADDR_W-1:0]   wr_base,
    input  logic [SIZE_W-1:0]   size_m1,
    input  logic [BURST_W-1:0]  burst_lim,
    input  logic                periph_req,
    input  logic                mem_gnt,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [LEN_W-1:0]    mem_len,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                busy,
    output logic                done,
    output logic [SIZE_W-1:0]   remain
);
    import dxe_pkg::*;

    localparam int CW = SIZE_W + 1;

    typedef struct packed {
        xfer_state_e        st;
        logic [ADDR_W-1:0]  ra;
        logic [ADDR_W-1:0]  wa;
        logic [SIZE_W-1:0]  rem;
        logic [BURST_W-1:0] bleft;
        logic [BURST_W-1:0] blim;
        logic [DATA_W-1:0]  hold;
        logic [2:0]         rwl;
        logic [2:0]         wwl;
        logic               rinc;
        logic               winc;
        logic               pace;
        logic               done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [LEN_W-1:0] beat_len;
    logic             last_beat;

    dxe_beat_calc #(
        .BUS_BYTES (BUS_BYTES),
        .SIZE_W    (SIZE_W),
        .BURST_W   (BURST_W),
        .LEN_W     (LEN_W)
    ) u_beat (
        .rd_wl      (c_q.rwl),
        .wr_wl      (c_q.wwl),
        .remain_m1  (c_q.rem),
        .burst_left (c_q.bleft),
        .beat_len   (beat_len)
    );

    assign last_beat = (({1'b0, c_q.rem} + CW'(1)) == CW'(beat_len));

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.ra    = rd_base;
                    c_d.wa    = wr_base;
                    c_d.rem   = size_m1;
                    c_d.blim  = burst_lim;
                    c_d.bleft = burst_lim;
                    c_d.rwl   = mode.rd_wl;
                    c_d.wwl   = mode.wr_wl;
                    c_d.rinc  = mode.rd_inc;
                    c_d.winc  = mode.wr_inc;
                    c_d.pace  = mode.pace_en;
                    c_d.st    = mode.pace_en ? ST_WAIT : ST_RD;
                end
            end
            ST_WAIT: begin
                if (periph_req) c_d.st = ST_RD;
            end
            ST_RD: begin
                if (mem_gnt) begin
                    c_d.hold = mem_rdata;
                    if (c_q.rinc) c_d.ra = c_q.ra + ADDR_W'(beat_len);
                    c_d.st = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_gnt) begin
                    if (c_q.winc) c_d.wa = c_q.wa + ADDR_W'(beat_len);
                    c_d.rem = c_q.rem - SIZE_W'(beat_len);
                    if (last_beat) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                    end else if (c_q.bleft == BURST_W'(beat_len)) begin
                        c_d.bleft = c_q.blim;
                        c_d.st    = c_q.pace ? ST_WAIT : ST_RD;
                    end else begin
                        c_d.bleft = c_q.bleft - BURST_W'(beat_len);
                        c_d.st    = ST_RD;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.rem <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_req   = (c_q.st == ST_RD) || (c_q.st == ST_WR);
    assign mem_we    = (c_q.st == ST_WR);
    assign mem_addr  = (c_q.st == ST_WR) ? c_q.wa : c_q.ra;
    assign mem_len   = beat_len;
    assign mem_wdata = c_q.hold;
    assign busy      = (c_q.st != ST_IDLE);
    assign done      = c_q.done;
    assign remain    = c_q.rem;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_len)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&remain && !busy));

    // R7
    rem_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_req && mem_we && mem_gnt)) |=> $stable(remain));

    // R10
    pace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_WAIT && !periph_req) |=> !mem_req);

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0 && int'(mem_len) <= BUS_BYTES));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 24,
    parameter int CFG_W      = 32,
    parameter int BUS_BYTES  = 8,
    parameter int BURST_MULT = 4,
    localparam int DATA_W    = 8 * BUS_BYTES,
    localparam int LEN_W     = $clog2(BUS_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    input  logic              periph_req,
    output logic              busy,
    output logic              done,
    output logic [SIZE_W-1:0] remain
);
    localparam int BURST_CAP = BUS_BYTES * BURST_MULT;
    localparam int BURST_W   = $clog2(((BURST_CAP > 256) ? BURST_CAP : 256) + 1);

    dxe_pkg::chan_mode_t mode;
    logic [ADDR_W-1:0]   rd_base, wr_base;
    logic [SIZE_W-1:0]   size_m1;
    logic [BURST_W-1:0]  burst_lim;

    dxe_cfg_regs #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .CFG_W  (CFG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .mode      (mode),
        .rd_base   (rd_base),
        .wr_base   (wr_base),
        .size_m1   (size_m1)
    );

    dxe_burst_limit #(
        .ADDR_W     (ADDR_W),
        .BUS_BYTES  (BUS_BYTES),
        .BURST_MULT (BURST_MULT),
        .BURST_W    (BURST_W)
    ) u_blim (
        .burst_m1 (mode.burst_m1),
        .rd_base  (rd_base),
        .wr_base  (wr_base),
        .limit    (burst_lim)
    );

    dxe_chan_ctrl #(
        .ADDR_W    (ADDR_W),
        .SIZE_W    (SIZE_W),
        .BUS_BYTES (BUS_BYTES),
        .BURST_W   (BURST_W),
        .LEN_W     (LEN_W),
        .DATA_W    (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .rd_base    (rd_base),
        .wr_base    (wr_base),
        .size_m1    (size_m1),
        .burst_lim  (burst_lim),
        .periph_req (periph_req),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .done       (done),
        .remain     (remain)
    );

endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_len;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_gnt = 1'b0;
    logic        periph_req = 1'b0;
    logic        busy, done;
    logic [23:0] remain;

    int total = 0;
    int bad = 0;
    logic [7:0] mem [0:4095];

    always #10 clk = ~clk;

    dma_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .periph_req(periph_req),
        .busy(busy), .done(done), .remain(remain)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unit_of(input int code);
        return 1 << ((code > 3) ? 3 : code);
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_xfer(input int rwl, input int wwl, input bit rinc, input bit winc,
                            input bit pace, input int bm1, input int ra, input int wa,
                            input int sm1, input int gpct, input int poke_at,
                            output int bursts_obs, output int bursts_exp);
        logic [31:0] v;
        int rb, wb, cap, blim, remb, mra, mwa, bleft, len;
        bit phase_wr, waiting, expect_done, prev_req, prev_hold, prev_p, finished, armed;
        logic [31:0] last_addr;
        logic        last_we;
        logic [63:0] saved, mask, rw;
        v = '0; v[2:0] = 3'(rwl); v[6:4] = 3'(wwl); v[8] = rinc; v[12] = winc;
        cfg_write(3'd0, v);
        v = '0; v[1] = pace; v[11:4] = 8'(bm1);
        cfg_write(3'd1, v);
        cfg_write(3'd2, 32'(ra));
        cfg_write(3'd3, 32'(wa));
        cfg_write(3'd4, 32'(sm1));
        rb = unit_of(rwl); wb = unit_of(wwl);
        cap = ((ra % 8) == 0 && (wa % 8) == 0) ? 32 : 24;
        blim = min2(bm1 + 1, cap);
        remb = sm1 + 1; mra = ra; mwa = wa; bleft = blim;
        phase_wr = 0; waiting = pace; expect_done = 0; prev_req = 0; prev_hold = 0;
        prev_p = 0; finished = 0; bursts_obs = 0; bursts_exp = 1;
        last_addr = '0; last_we = 0; saved = '0;
        @(negedge clk);
        start = 1'b1; periph_req = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int it = 0; it < 4000; it++) begin
            if (it > 0) @(negedge clk);
            mem_gnt = 1'b0;
            armed = 0;
            if (it == poke_at) begin
                cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'd2; start = 1'b1;
            end else if (it == poke_at + 1) begin
                cfg_we = 1'b0; start = 1'b0;
            end
            if (expect_done) begin
                chk(done === 1'b1, "R8 done pulse high", 64'(done), 1);
                chk(busy === 1'b0, "R8 busy low at done", 64'(busy), 0);
                chk(remain === 24'hFFFFFF, "R7 all ones when finished", 64'(remain), 64'hFFFFFF);
                @(negedge clk);
                chk(done === 1'b0, "R8 done one cycle", 64'(done), 0);
                finished = 1;
                break;
            end
            if (done) chk(0, "R8 early done", 1, 0);
            if (waiting && prev_p) waiting = 0;
            if (waiting) chk(!mem_req, "R10 no request while waiting", 64'(mem_req), 0);
            if (prev_hold)
                chk(mem_req && mem_addr == last_addr && mem_we == last_we,
                    "R6 request held", 64'(mem_addr), 64'(last_addr));
            if (mem_req && !prev_req) bursts_obs++;
            prev_req = mem_req;
            prev_hold = 0;
            if (mem_req && !waiting) begin
                len = min2(min2(rb, wb), min2(remb, bleft));
                chk(mem_we == phase_wr, "R5 read then write order", 64'(mem_we), 64'(phase_wr));
                chk(int'(mem_len) == len, "R3 beat length", 64'(mem_len), 64'(len));
                chk(mem_addr == 32'(phase_wr ? mwa : mra), "R4 beat address", 64'(mem_addr),
                    64'(phase_wr ? mwa : mra));
                if (int'($urandom % 100) < gpct) begin
                    mem_gnt = 1'b1;
                    if (!phase_wr) begin
                        rw = '0;
                        for (int j = 0; j < 8; j++)
                            if (j < len) rw[8*j +: 8] = mem[(mra + j) & 12'hFFF];
                        mem_rdata = rw;
                        saved = rw;
                        if (rinc) mra += len;
                        phase_wr = 1;
                    end else begin
                        mask = (len >= 8) ? '1 : ((64'd1 << (8 * len)) - 64'd1);
                        chk((mem_wdata & mask) == (saved & mask), "R5 write data",
                            mem_wdata & mask, saved & mask);
                        chk(remain == 24'(remb - 1), "R7 remaining count", 64'(remain), 64'(remb - 1));
                        for (int j = 0; j < 8; j++)
                            if (j < len) mem[(mwa + j) & 12'hFFF] = mem_wdata[8*j +: 8];
                        if (winc) mwa += len;
                        remb -= len;
                        phase_wr = 0;
                        if (remb == 0) expect_done = 1;
                        else if (bleft == len) begin
                            bleft = blim;
                            if (pace) begin waiting = 1; armed = 1; bursts_exp++; end
                        end else bleft -= len;
                    end
                end else begin
                    prev_hold = 1;
                    last_addr = mem_addr;
                    last_we = mem_we;
                end
            end
            if (waiting && !armed && !(it == 0 && 0)) periph_req = (($urandom % 100) < 40);
            else periph_req = 1'b0;
            prev_p = periph_req;
        end
        mem_gnt = 1'b0;
        periph_req = 1'b0;
        cfg_we = 1'b0;
        start = 1'b0;
        if (!finished) chk(0, "R8 transfer did not finish", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int bo, be, mism;
        logic [7:0] snap [0:63];
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 13 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after reset", 64'(busy), 0);
        chk(done === 1'b0, "R1 done after reset", 64'(done), 0);
        chk(mem_req === 1'b0, "R1 no request after reset", 64'(mem_req), 0);
        chk(remain === 24'hFFFFFF, "R1 remain all ones", 64'(remain), 64'hFFFFFF);

        // R5 memcpy with full grant, then compare destination
        for (int i = 0; i < 64; i++) snap[i] = mem[12'h100 + i];
        run_xfer(3, 3, 1, 1, 0, 255, 32'h100, 32'h900, 63, 100, -10, bo, be);
        mism = 0;
        for (int i = 0; i < 64; i++) if (mem[12'h900 + i] != snap[i]) mism++;
        chk(mism == 0, "R5 destination matches source", 64'(mism), 0);

        // R7 single byte
        run_xfer(3, 3, 1, 1, 0, 255, 32'h140, 32'h940, 0, 60, -10, bo, be);

        // R9 aligned cap 32 -> 2 bursts for 64 bytes
        run_xfer(3, 3, 1, 1, 1, 255, 32'h200, 32'hA00, 63, 80, -10, bo, be);
        chk(bo == 2 && be == 2, "R9 aligned burst count", 64'(bo), 2);
        // R9 unaligned cap 24 -> 3 bursts
        run_xfer(3, 3, 1, 1, 1, 255, 32'h201, 32'hA00, 63, 80, -10, bo, be);
        chk(bo == 3 && be == 3, "R9 unaligned burst count", 64'(bo), 3);
        // R10 small burst of 6 bytes with 4-byte widths -> 4 bursts for 24 bytes
        run_xfer(2, 2, 1, 1, 1, 5, 32'h300, 32'hB00, 23, 70, -10, bo, be);
        chk(bo == 4 && be == 4, "R10 paced burst count", 64'(bo), 4);

        // R4 fixed write address, 1-byte writes
        run_xfer(2, 0, 1, 0, 0, 255, 32'h380, 32'hC00, 11, 70, -10, bo, be);
        // R4 fixed read address
        run_xfer(1, 3, 0, 1, 0, 255, 32'h3C0, 32'hC40, 9, 70, -10, bo, be);
        // R3 width codes above 3 act as 8 bytes
        run_xfer(7, 5, 1, 1, 0, 255, 32'h400, 32'hD00, 15, 90, -10, bo, be);
        // R2 start and size writes while busy are ignored
        run_xfer(0, 1, 1, 1, 0, 255, 32'h440, 32'hD40, 20, 70, 3, bo, be);

        for (int k = 0; k < 30; k++) begin
            int rwl, wwl, bm1, ra, wa, sm1, gp;
            bit ri, wi, pc;
            rwl = int'($urandom % 5); wwl = int'($urandom % 5);
            ri = 1'($urandom % 2); wi = 1'($urandom % 2); pc = 1'($urandom % 2);
            bm1 = int'($urandom % 40); ra = int'($urandom % 2048);
            wa = 2048 + int'($urandom % 1900); sm1 = int'($urandom % 60);
            gp = 40 + int'($urandom % 60);
            run_xfer(rwl, wwl, ri, wi, pc, bm1, ra, wa, sm1, gp, -10, bo, be);
            chk(bo == be, "R9 random burst count", 64'(bo), 64'(be));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule